// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog Reset

The block is a 32-bit free-running counter that advances on each clock cycle in which `tick` is high. Every cycle it is compared against four match registers. Each comparator has a bit in an interrupt enable mask. A comparator whose enable bit is 1 latches a sticky status bit when it matches. Software clears status bits by writing 1 to them. The interrupt output is the OR of all status bits.

The highest-numbered comparator (channel 3) can also serve as a watchdog. Once the watchdog enable is set, a channel-3 match drives `wdt_rst` high for a fixed number of clocks, 256 by default. It also sets a reset-cause flag that software can read after the rest of the chip comes out of reset. The watchdog enable, the cause flag and the pulse counter use only the external reset `rst_n`, so the pulse this block generates does not clear them. The normal servicing sequence is: read the counter, add a timeout, write the sum to match register 3. The sum may wrap past zero.

Software reaches the registers through a single-cycle synchronous bus. A write commits at the clock edge, and read data is a combinational function of `addr`.

Top module: `ostmr_wdt`

## Requirements
- R1: After `rst_n` is low, every register reads 0, and `irq` and `wdt_rst` are 0. Register map on `addr`: 0..3 hold match values 0..3; 4 is the counter; 5 is the enable mask (bits 3:0); 6 is the status (bits 3:0); 7 is the watchdog enable (bit 0); 8 is the reset cause (bit 0). Any other address reads 0.
- R2: The counter adds 1 at each clock edge where `tick` is 1, holds its value where `tick` is 0, and wraps from 0xFFFFFFFF to 0. A write to address 4 loads the counter, and that write takes priority over the increment.
- R3: When the counter equals match register n and enable bit n is 1, status bit n reads 1 from the next cycle on. When enable bit n is 0, the match leaves status bit n unchanged.
- R4: Bits 31:4 of the enable register always read 0. Clearing an enable bit leaves a status bit that is already set at 1.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If that channel's enabled match occurs in the same cycle as the clear, the bit stays 1.
- R6: `irq` is 1 exactly when at least one status bit is 1.
- R7: Writing 1 to bit 0 of address 7 enables the watchdog. After that, writes cannot clear the bit; only `rst_n` clears it.
- R8: With the watchdog enabled, a channel-3 match raises `wdt_rst` at the next clock edge. `wdt_rst` then stays high for exactly 256 cycles. A match that occurs while the pulse is running does not restart it.
- R9: A watchdog trigger sets bit 0 of address 8. The bit stays set through the pulse and afterwards. Writing 1 to the bit clears it.
- R10: A match value computed as counter plus timeout, wrapping past 0xFFFFFFFF, matches at the correct count after the counter itself wraps.
- R11: With the watchdog disabled, a channel-3 match never raises `wdt_rst`. The match still sets status bit 3 if enable bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low full external reset |
| tick | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | OR of the status bits |
| wdt_rst | output | 1 | Watchdog-generated reset pulse |

## Verification
The assertions assume that `tick`, `wr_en`, `addr` and `wdata` are stable around each rising edge. The bench meets this by driving all inputs on the falling edge. The pulse-length and sticky-bit properties also assume that `rst_n` does not drop in the middle of a pulse; the bench asserts reset only at the start. To keep any match cycle exact, the bench stops `tick` before it reloads the counter or a match register, so no sequence of register writes races the counter.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned WD_CH  = NUM_CH - 1;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [3:0] A_COUNT = 4'd4;
  localparam logic [3:0] A_IEN   = 4'd5;
  localparam logic [3:0] A_STAT  = 4'd6;
  localparam logic [3:0] A_WDEN  = 4'd7;
  localparam logic [3:0] A_CAUSE = 4'd8;

  function automatic word_t count_next(word_t cur, logic adv, logic load, word_t val);
    if (load) return val;
    if (adv) return cur + word_t'(1);
    return cur;
  endfunction

  function automatic logic [NUM_CH-1:0] sticky_next(logic [NUM_CH-1:0] cur,
                                                     logic [NUM_CH-1:0] set,
                                                     logic [NUM_CH-1:0] clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter
  import ostmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  word_t load_val,
  output word_t count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_next(count, tick, load, load_val);
  end

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (count == $past(count) + word_t'(1)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
endmodule

// File: rtl/ostmr_channel.sv
module ostmr_channel
  import ostmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t count,
  input  logic  wr_match,
  input  word_t wdata,
  output word_t match_q,
  output logic  hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        match_q <= '0;
    else if (wr_match) match_q <= wdata;
  end

  assign hit = (count == match_q);
endmodule

// File: rtl/ostmr_wdog.sv
module ostmr_wdog #(
  parameter int unsigned PULSE_LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int unsigned CW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - CW'(1);
    end else if (fire) begin
      busy <= 1'b1;
      left <= LAST;
    end
  end

  a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !busy) |=> (busy && left == LAST));
  a_r8_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left != '0) |=> busy);
  a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left == '0) |=> !busy);
endmodule

// File: rtl/ostmr_wdt.sv
module ostmr_wdt
  import ostmr_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        wdt_rst
);
  word_t                     count;
  word_t [NUM_CH-1:0]        match_q;
  logic  [NUM_CH-1:0]        hit;
  logic  [NUM_CH-1:0]        ien_q, status_q, stat_clr, stat_set;
  logic                      wden_q, cause_q, wd_fire, cause_clr;

  ostmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(wr_en && addr == A_COUNT), .load_val(wdata), .count(count)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ostmr_channel u_ch (
      .clk(clk), .rst_n(rst_n), .count(count),
      .wr_match(wr_en && addr == 4'(c)), .wdata(wdata),
      .match_q(match_q[c]), .hit(hit[c])
    );
  end

  assign stat_clr  = (wr_en && addr == A_STAT)  ? wdata[NUM_CH-1:0] : '0;
  assign cause_clr = wr_en && addr == A_CAUSE && wdata[0];
  assign stat_set  = hit & ien_q;
  assign wd_fire   = wden_q && hit[WD_CH] && !wdt_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= '0;
      status_q <= '0;
      wden_q   <= 1'b0;
      cause_q  <= 1'b0;
    end else begin
      if (wr_en && addr == A_IEN) ien_q <= wdata[NUM_CH-1:0];
      if (wr_en && addr == A_WDEN) wden_q <= wden_q | wdata[0];
      status_q <= sticky_next(status_q, stat_set, stat_clr);
      cause_q  <= wd_fire | (cause_q & ~cause_clr);
    end
  end

  ostmr_wdog #(.PULSE_LEN(PULSE_LEN)) u_wd (
    .clk(clk), .rst_n(rst_n), .fire(wd_fire), .busy(wdt_rst)
  );

  assign irq = |status_q;

  always_comb begin
    rdata = '0;
    if (addr < 4'(NUM_CH)) rdata = match_q[addr[1:0]];
    else begin
      case (addr)
        A_COUNT: rdata = count;
        A_IEN:   rdata[NUM_CH-1:0] = ien_q;
        A_STAT:  rdata[NUM_CH-1:0] = status_q;
        A_WDEN:  rdata[0] = wden_q;
        A_CAUSE: rdata[0] = cause_q;
        default: rdata = '0;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[c] && ien_q[c]) |=> status_q[c]);
    a_r4_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[c] && !stat_clr[c]) |=> status_q[c]);
  end
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wden_q |=> wden_q);
  a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> (cause_q && wdt_rst));
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wden_q && !wdt_rst) |=> !wdt_rst);
  a_r6_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_set) |=> irq);
endmodule

// File: tb/test_ostmr_wdt.sv
module test_ostmr_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wdt_rst;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ostmr_wdt i_ostmr_wdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wdt_rst(wdt_rst)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic run(int n);
    tick = 1'b1; step(n); tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d); chk("R1 reg reset", d, 32'h0);
    end
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    chk("R1 wdt_rst reset", {31'b0, wdt_rst}, 32'h0);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    wr(4'd4, 32'd500);
    step(3);
    rd(4'd4, d); chk("R2 hold without tick", d, 32'd500);
    run(7);
    rd(4'd4, d); chk("R2 advance by ticks", d, 32'd507);
    wr(4'd4, 32'hFFFF_FFFE);
    run(3);
    rd(4'd4, d); chk("R2 wrap to zero", d, 32'h1);
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(4'd4, 32'd1000);
    wr(4'd0, 32'd1003); wr(4'd1, 32'd1005); wr(4'd2, 32'd1007);
    wr(4'd5, 32'h5);
    run(10);
    rd(4'd6, d); chk("R3 enabled matches only", d, 32'h5);
    chk("R6 irq with status", {31'b0, irq}, 32'h1);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, d); chk("R4 reserved enable bits", d, 32'hF);
    wr(4'd5, 32'h0);
    rd(4'd6, d); chk("R4 status kept after disable", d, 32'h5);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(4'd6, 32'h1);
    rd(4'd6, d); chk("R5 write-one clear", d, 32'h4);
    wr(4'd6, 32'h0);
    rd(4'd6, d); chk("R5 write-zero no effect", d, 32'h4);
    wr(4'd5, 32'h4);
    wr(4'd4, 32'd1007);
    wr(4'd6, 32'h4);
    rd(4'd6, d); chk("R5 match beats clear", d, 32'h4);
    wr(4'd4, 32'd3000);
    wr(4'd6, 32'hF);
    rd(4'd6, d); chk("R5 cleared", d, 32'h0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_wd_off();
    logic [31:0] d;
    int seen = 0;
    wr(4'd5, 32'h8);
    wr(4'd4, 32'd2000);
    wr(4'd3, 32'd2002);
    tick = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (wdt_rst) seen++;
    end
    tick = 1'b0;
    chk("R11 no reset when disabled", seen, 0);
    rd(4'd6, d); chk("R11 status3 set", d, 32'h8);
    wr(4'd6, 32'hF);
  endtask

  task automatic t_wd_on();
    logic [31:0] d;
    int wait_n = 0;
    int hi = 0;
    wr(4'd7, 32'h1);
    wr(4'd7, 32'h0);
    rd(4'd7, d); chk("R7 enable sticky", d, 32'h1);
    wr(4'd4, 32'hFFFF_FFF0);
    wr(4'd3, 32'hFFFF_FFF0 + 32'h20);
    rd(4'd3, d); chk("R10 wrapped match value", d, 32'h10);
    tick = 1'b1;
    while (!wdt_rst && wait_n < 100) begin step(1); wait_n++; end
    rd(4'd4, d); chk("R8 R10 pulse starts after match edge", d, 32'h11);
    rd(4'd8, d); chk("R9 cause set", d, 32'h1);
    while (wdt_rst && hi < 400) begin step(1); hi++; end
    tick = 1'b0;
    chk("R8 pulse length", hi, 256);
    rd(4'd8, d); chk("R9 cause kept after pulse", d, 32'h1);
    rd(4'd6, d); chk("R10 status3 after wrap", d, 32'h8);
    wr(4'd3, 32'h8000_0000);
    wr(4'd8, 32'h1);
    rd(4'd8, d); chk("R9 cause cleared", d, 32'h0);
    run(20);
    chk("R8 no retrigger", {31'b0, wdt_rst}, 32'h0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_counter();
    t_match();
    t_clear();
    t_wd_off();
    t_wd_on();
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=%0d expected=done", n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule